// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction on every clock edge. It handles word loads and stores, the register-to-register operations add, subtract, AND, OR and signed set-on-less-than, an equality branch, and an absolute jump. It holds its own program counter and a 32-entry register file with two read ports and one write port. An ALU, a decoder, and separate instruction and data word memories complete the core.

Both memories are filled through a preload port, normally while reset is held. After that the core runs by itself. Its progress is visible on the debug outputs, which show the current PC and the register-file write port in the cycle the write is committed. The reset input is asynchronous and active low. Its release is synchronised inside the core, so execution starts on the third rising edge after the release.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the PC reads 0 and no register or data-memory write occurs. After release, the first two rising edges leave the PC at 0 with no writes, and the instruction at address 0 commits on the third edge.
- R2: Every instruction other than a taken branch or a jump advances the PC by 4. This includes stores, untaken branches and no-ops.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and function [5:0]. Opcode 0 with function 0x20/0x22/0x24/0x25/0x2A writes rs+rt, rs-rt, rs&rt, rs|rt, or 1/0 for signed rs<rt into rd.
- R4: Opcode 35 loads the data word at rs plus the sign-extended 16-bit offset [15:0] (word index = address bits [MEM_AW+1:2]) into rt.
- R5: Opcode 43 writes rt to the data word at rs plus the sign-extended offset on the rising edge, and writes no register.
- R6: Opcode 4 branches to PC+4 plus the sign-extended offset shifted left by two when rs equals rt, and otherwise falls through to PC+4. It writes no register.
- R7: Opcode 2 sets the PC to the current PC bits [31:28], then bits [25:0] of the instruction, then two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it still shows on the debug write port but leaves it at zero.
- R9: An unrecognised opcode, or opcode 0 with an unrecognised function code, writes nothing and only advances the PC.
- R10: The preload port writes `load_data` into the instruction memory (`load_dmem`=0) or the data memory (`load_dmem`=1) at word `load_addr` on a rising edge with `load_we`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_we | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | MEM_AW | Preload word index |
| load_data | input | XLEN | Preload word |
| dbg_pc | output | XLEN | Current program counter |
| dbg_we | output | 1 | Register write committed this cycle |
| dbg_waddr | output | 5 | Register written this cycle |
| dbg_wdata | output | XLEN | Value written this cycle |

## Verification
The hardest cases to reach from the ports are the paths that change control flow or suppress a write. These are a taken branch that skips a writing instruction, a jump over writing instructions, a write to register 0 followed by a read of it, and the no-op encodings. A single preloaded program puts each of these in sequence behind loads of known, partly negative data. Every skipped or suppressed write would then surface as a wrong debug-port value. A reset asserted mid-run while the core sits in a branch-to-self loop exercises the asynchronous entry and the two-cycle synchronised release a second time. It does so with register and memory contents left over from the first run.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int OPW = 6;
  localparam int RAW = 5;
  localparam int NREG = 1 << RAW;

  localparam logic [OPW-1:0] OP_ALU   = 6'd0;
  localparam logic [OPW-1:0] OP_JUMP  = 6'd2;
  localparam logic [OPW-1:0] OP_BEQ   = 6'd4;
  localparam logic [OPW-1:0] OP_LOAD  = 6'd35;
  localparam logic [OPW-1:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;
    logic    alu_imm;
    logic    mem_write;
    logic    mem_to_reg;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  input  logic [5:0]     funct,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl = '{reg_write: 1'b0, dst_rd: 1'b0, alu_imm: 1'b0, mem_write: 1'b0,
             mem_to_reg: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OP_ALU: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctrl.alu_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  raddr_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs_q [NREG];

  genvar g;
  generate
    for (g = 1; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (we && (waddr == RAW'(g))) regs_q[g] <= wdata;
      end
    end
  endgenerate

  assign regs_q[0] = '0;
  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int XLEN = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [XLEN-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic              load_dmem,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_we,
  output logic [RAW-1:0]    dbg_waddr,
  output logic [XLEN-1:0]   dbg_wdata
);
  localparam int IMMW = 16;
  localparam int JW   = 26;
  localparam int PCHI = XLEN - JW - 2;

  logic [1:0]        sync_q;
  logic              run;
  logic [XLEN-1:0]   pc_q, pc_d, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0]   instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dmem_rd, wb_data;
  logic              alu_zero, rf_we, st_we;
  logic [RAW-1:0]    wr_reg;
  ctrl_t             ctrl;
  logic              dm_we;
  logic [MEM_AW-1:0] dm_waddr;
  logic [XLEN-1:0]   dm_wdata;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  // program counter
  always_comb begin
    pc_plus4   = pc_q + XLEN'(4);
    br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    jmp_target = {pc_q[XLEN-1 -: PCHI], instr[JW-1:0], 2'b00};
    if (ctrl.jump)                    pc_d = jmp_target;
    else if (ctrl.branch && alu_zero) pc_d = br_target;
    else                              pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  sc_wordmem #(.XLEN(XLEN), .AW(MEM_AW)) u_imem (
    .clk(clk), .we(load_we && !load_dmem), .waddr(load_addr), .wdata(load_data),
    .raddr(pc_q[MEM_AW+1:2]), .rdata(instr)
  );

  sc_decoder u_dec (
    .opcode(instr[XLEN-1 -: OPW]), .funct(instr[5:0]), .ctrl(ctrl)
  );

  assign imm_ext = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
  assign wr_reg  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we   = run && ctrl.reg_write;
  assign st_we   = run && ctrl.mem_write;

  sc_regfile #(.XLEN(XLEN)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wr_reg), .wdata(wb_data),
    .raddr_a(instr[25:21]), .raddr_b(instr[20:16]),
    .rdata_a(rs_val), .rdata_b(rt_val)
  );

  assign alu_b = ctrl.alu_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  // preload port has priority over core stores
  always_comb begin
    if (load_we && load_dmem) begin
      dm_we    = 1'b1;
      dm_waddr = load_addr;
      dm_wdata = load_data;
    end else begin
      dm_we    = st_we;
      dm_waddr = alu_y[MEM_AW+1:2];
      dm_wdata = rt_val;
    end
  end

  sc_wordmem #(.XLEN(XLEN), .AW(MEM_AW)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(alu_y[MEM_AW+1:2]), .rdata(dmem_rd)
  );

  assign wb_data   = ctrl.mem_to_reg ? dmem_rd : alu_y;
  assign dbg_pc    = pc_q;
  assign dbg_we    = rf_we;
  assign dbg_waddr = wr_reg;
  assign dbg_wdata = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            reg_we,
  input logic            mem_we
);
  logic [OPW-1:0] op;
  logic           known_op;
  assign op = instr[XLEN-1 -: OPW];
  assign known_op = (op == OP_ALU) || (op == OP_JUMP) || (op == OP_BEQ) ||
                    (op == OP_LOAD) || (op == OP_STORE);

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!reg_we && !mem_we));

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op != OP_BEQ && op != OP_JUMP) |=> (pc == $past(pc) + XLEN'(4)));

  assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_STORE) |-> (mem_we && !reg_we));

  assert_beq_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_BEQ && rs_val == rt_val) |=>
      (pc == $past(pc) + XLEN'(4) +
             {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  assert_beq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_BEQ && rs_val != rt_val) |=> (pc == $past(pc) + XLEN'(4)));

  assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_JUMP) |=>
      (pc == {$past(pc[XLEN-1 -: XLEN-28]), $past(instr[25:0]), 2'b00}));

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == '0) |-> (rs_val == '0));

  assert_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !known_op) |-> (!reg_we && !mem_we));
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .instr(instr), .pc(pc_q),
  .rs_val(rs_val), .rt_val(rt_val), .reg_we(dbg_we), .mem_we(st_we)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  localparam int XLEN = 32;
  localparam int MEM_AW = 6;
  localparam int DEPTH = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_we = 1'b0;
  logic              load_dmem = 1'b0;
  logic [MEM_AW-1:0] load_addr = '0;
  logic [XLEN-1:0]   load_data = '0;
  logic [XLEN-1:0]   dbg_pc;
  logic              dbg_we;
  logic [4:0]        dbg_waddr;
  logic [XLEN-1:0]   dbg_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_reg  [32];
  logic [31:0] m_imem [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_pc;

  always #10 clk = ~clk;

  sc_core #(.XLEN(XLEN), .MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .dbg_pc(dbg_pc),
    .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata)
  );

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of the reference model: compare, then commit
  task automatic model_step(string pc_tag);
    logic [31:0] ins, a, b, imm, res, nxt;
    logic [5:0]  op, fn;
    logic        we, st;
    logic [4:0]  wa;
    string       tag;
    ins = m_imem[(m_pc >> 2) % DEPTH];
    op = ins[31:26]; fn = ins[5:0];
    a = m_reg[ins[25:21]]; b = m_reg[ins[20:16]];
    imm = {{16{ins[15]}}, ins[15:0]};
    we = 0; st = 0; wa = ins[20:16]; res = 0; nxt = m_pc + 4; tag = "R9";
    case (op)
      6'd0: begin
        wa = ins[15:11]; we = 1; tag = "R3";
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin we = 0; tag = "R9"; end
        endcase
      end
      6'd35: begin we = 1; res = m_dmem[((a + imm) >> 2) % DEPTH]; tag = "R4"; end
      6'd43: begin st = 1; tag = "R5"; end
      6'd4:  begin tag = "R6"; if (a == b) nxt = m_pc + 4 + (imm << 2); end
      6'd2:  begin tag = "R7"; nxt = {m_pc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (we && wa == 0) tag = "R8";
    check({pc_tag, " pc"}, dbg_pc, m_pc);
    check({tag, " we"}, {31'd0, dbg_we}, {31'd0, we});
    if (we) begin
      check({tag, " waddr"}, {27'd0, dbg_waddr}, {27'd0, wa});
      check({tag, " wdata"}, dbg_wdata, res);
      if (wa != 0) m_reg[wa] = res;
    end
    if (st) m_dmem[((a + imm) >> 2) % DEPTH] = b;
    m_pc = nxt;
  endtask

  task automatic run_cycles(int n);
    string pc_tag;
    pc_tag = "R2";
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k < 2) begin
        check("R1 pc after release", dbg_pc, 32'd0);
        check("R1 we after release", {31'd0, dbg_we}, 32'd0);
      end else begin
        logic [5:0] op;
        op = m_imem[(m_pc >> 2) % DEPTH][31:26];
        model_step(pc_tag);
        pc_tag = (op == 6'd4) ? "R6" : (op == 6'd2) ? "R7" : "R2";
      end
    end
  endtask

  task automatic reset_checks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R1 pc in reset", dbg_pc, 32'd0);
      check("R1 we in reset", {31'd0, dbg_we}, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_imem[i] = 32'd0;
      m_dmem[i] = 32'h1000_0000 + i;
    end
    m_dmem[0] = 32'd5; m_dmem[1] = 32'd7; m_dmem[2] = 32'hFFFF_FFF0;
    m_imem[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    m_imem[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    m_imem[2]  = enc_i(6'd35, 5'd0, 5'd3, 16'd8);
    m_imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h20);
    m_imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h22);
    m_imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h24);
    m_imem[6]  = enc_r(5'd1, 5'd2, 5'd7, 6'h25);
    m_imem[7]  = enc_r(5'd3, 5'd1, 5'd8, 6'h2A);
    m_imem[8]  = enc_r(5'd1, 5'd3, 5'd9, 6'h2A);
    m_imem[9]  = enc_i(6'd43, 5'd0, 5'd4, 16'd16);
    m_imem[10] = enc_i(6'd35, 5'd0, 5'd10, 16'd16);
    m_imem[11] = enc_r(5'd1, 5'd2, 5'd0, 6'h20);
    m_imem[12] = enc_r(5'd0, 5'd1, 5'd11, 6'h20);
    m_imem[13] = enc_i(6'd4, 5'd1, 5'd2, 16'd5);
    m_imem[14] = enc_i(6'd4, 5'd6, 5'd1, 16'd1);
    m_imem[15] = enc_r(5'd1, 5'd1, 5'd12, 6'h20);
    m_imem[16] = {6'h3F, 26'h0A5_5A5A};
    m_imem[17] = enc_r(5'd1, 5'd2, 5'd17, 6'h00);
    m_imem[18] = enc_i(6'd35, 5'd4, 5'd13, 16'hFFFC);
    m_imem[19] = {6'd2, 26'd22};
    m_imem[20] = enc_r(5'd1, 5'd1, 5'd14, 6'h20);
    m_imem[21] = enc_r(5'd1, 5'd1, 5'd14, 6'h22);
    m_imem[22] = enc_r(5'd3, 5'd3, 5'd15, 6'h2A);
    m_imem[23] = enc_r(5'd3, 5'd1, 5'd16, 6'h22);
    m_imem[24] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_pc = 32'd0;

    // R10: preload both memories during reset
    for (int i = 0; i < 2 * DEPTH; i++) begin
      @(negedge clk);
      load_we = 1'b1;
      load_dmem = (i >= DEPTH);
      load_addr = MEM_AW'(i % DEPTH);
      load_data = (i >= DEPTH) ? m_dmem[i - DEPTH] : m_imem[i];
    end
    @(negedge clk);
    load_we = 1'b0;
    reset_checks(3);
    rst_n = 1'b1;
    run_cycles(40);
    // asynchronous reset in the middle of a branch-to-self loop
    rst_n = 1'b0;
    m_pc = 32'd0;
    #1;
    check("R1 pc async", dbg_pc, 32'd0);
    reset_checks(3);
    rst_n = 1'b1;
    run_cycles(40);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule